// File: doc/BRIEF.md
# Bit-Per-Way Pseudo-LRU Replacement Controller

This block picks which way of a set-associative cache to evict. Each set has one recency flag per way. Every access to a way raises that way's flag. When raising a flag would leave all flags of the set high, the other flags of that set drop and only the one just raised stays high. As a result, an evicted way has not been touched since the last moment when every way of its set had been used.

A victim request names a set, and the block returns a victim way in the same cycle. The victim is always a way whose flag is low. When several ways qualify, a free-running 16-bit LFSR chooses a rotating start point, and the scan takes the first qualifying way from there. Filling the chosen victim is reported back on the ordinary access port, so it updates the flags in the same way as any other access. Tag storage, data arrays, hit detection and write policy belong to the surrounding cache.

Top module: `plru_bitway`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every flag of every set to 0. In the first cycle after reset, the victim of any set equals the LFSR start point.
- R2: An access (`acc_vld` high) with set `acc_set` and way `acc_way` sets that way's flag at the next clock edge.
- R3: When an access would leave all flags of its set at 1, that set's flags become one-hot on the accessed way.
- R4: The returned victim always has its flag at 0.
- R5: The victim is the first way with a 0 flag found by scanning upward, modulo WAYS, from the start point. The start point is the LFSR's low log2(WAYS) bits. WAYS is a power of two.
- R6: The LFSR loads 16'hACE1 on reset. On every other clock edge it shifts left, and its new bit 0 is the XOR of bits 15, 13, 12 and 10. It never reaches zero.
- R7: When an access and a victim request name the same set in the same cycle, the victim is taken from the flags as they were before that access.
- R8: An access changes only the flags of its own set.
- R9: `vic_way` is combinational from the stored flags, the LFSR and `vic_set`, and is valid in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access strobe (hit or fill) |
| acc_set | input | log2(SETS) | Set index of the access |
| acc_way | input | log2(WAYS) | Way used by the access |
| vic_req | input | 1 | Victim request |
| vic_set | input | log2(SETS) | Set index of the victim request |
| vic_way | output | log2(WAYS) | Chosen victim way |

## Verification
Every cycle, the checker confirms four things: a requested victim's flag is low, an accessed way's flag is high one cycle later, no set ever holds all flags high, and the LFSR never reaches zero. The reset clearing is also checked against the stored flags. The exact victim choice from the rotation start (R5), the pre-update view on a same-set collision (R7) and the isolation between sets (R8) can only be shown by the bench. It compares each victim against a reference model of the flags and the LFSR under random and directed traffic.

// File: rtl/plru_bitway.sv
module plru_bitway #(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_vld,
  input  logic [$clog2(SETS)-1:0] acc_set,
  input  logic [$clog2(WAYS)-1:0] acc_way,
  input  logic                    vic_req,
  input  logic [$clog2(SETS)-1:0] vic_set,
  output logic [$clog2(WAYS)-1:0] vic_way
);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [15:0] SEED = 16'hACE1;

  logic [SETS-1:0][WAYS-1:0] flags;
  logic [15:0]               lfsr;
  logic [WAYS-1:0]           hot, merged, row_nxt, vrow;
  logic [WAY_W-1:0]          start;

  assign hot     = WAYS'(1) << acc_way;
  assign merged  = flags[acc_set] | hot;
  assign row_nxt = (&merged) ? hot : merged;
  assign vrow    = flags[vic_set];
  assign start   = lfsr[WAY_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr  <= SEED;
      flags <= '0;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (acc_vld) flags[acc_set] <= row_nxt;
    end
  end

  always_comb begin
    logic             found;
    logic [WAY_W-1:0] idx;
    found   = 1'b0;
    vic_way = start;
    for (int k = 0; k < WAYS; k++) begin
      idx = start + WAY_W'(k);
      if (!found && !vrow[idx]) begin
        vic_way = idx;
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/plru_bitway_chk.sv
module plru_bitway_chk #(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    acc_vld,
  input logic [$clog2(SETS)-1:0] acc_set,
  input logic [$clog2(WAYS)-1:0] acc_way,
  input logic                    vic_req,
  input logic [$clog2(SETS)-1:0] vic_set,
  input logic [$clog2(WAYS)-1:0] vic_way,
  input logic [SETS-1:0][WAYS-1:0] flags,
  input logic [15:0]             lfsr
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk)
    if (rst_q) a_r1_reset_clear: assert (flags == '0);

  a_r4_victim_clear: assert property (@(posedge clk) disable iff (rst)
    vic_req |-> !flags[vic_set][vic_way]);

  a_r2_flag_set: assert property (@(posedge clk) disable iff (rst)
    acc_vld |=> flags[$past(acc_set)][$past(acc_way)]);

  a_r3_never_full: assert property (@(posedge clk) disable iff (rst)
    acc_vld |=> !(&flags[$past(acc_set)]));

  a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsr != 16'h0);
endmodule

bind plru_bitway plru_bitway_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_set(acc_set), .acc_way(acc_way),
  .vic_req(vic_req), .vic_set(vic_set), .vic_way(vic_way),
  .flags(flags), .lfsr(lfsr)
);

// File: tb/tb_plru_bitway.sv
module tb_plru_bitway;
  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int WW = $clog2(WAYS);
  localparam int SW = $clog2(SETS);

  logic clk = 1'b0, rst = 1'b1;
  logic acc_vld = 1'b0, vic_req = 1'b0;
  logic [SW-1:0] acc_set = '0, vic_set = '0;
  logic [WW-1:0] acc_way = '0, vic_way;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  plru_bitway #(.WAYS(WAYS), .SETS(SETS)) dut (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_set(acc_set), .acc_way(acc_way),
    .vic_req(vic_req), .vic_set(vic_set), .vic_way(vic_way));

  logic [SETS-1:0][WAYS-1:0] mflags;
  logic [15:0] mlfsr;

  function automatic logic [WAYS-1:0] upd(logic [WAYS-1:0] row, logic [WW-1:0] w);
    logic [WAYS-1:0] r;
    r = row;
    r[w] = 1'b1;
    if (&r) begin r = '0; r[w] = 1'b1; end
    return r;
  endfunction

  function automatic logic [WW-1:0] pick(logic [WAYS-1:0] row, logic [WW-1:0] st);
    for (int k = 0; k < WAYS; k++)
      if (!row[(int'(st) + k) % WAYS]) return WW'((int'(st) + k) % WAYS);
    return st;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mflags <= '0;
      mlfsr  <= 16'hACE1;
    end else begin
      mlfsr <= {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
      if (acc_vld) mflags[acc_set] <= upd(mflags[acc_set], acc_way);
    end
  end

  task automatic chk(string tag, logic [WW-1:0] exp);
    n_cmp++;
    if (vic_way !== exp) begin
      n_bad++;
      $display("FAIL %s: vic_way=%0d expected %0d", tag, vic_way, exp);
    end
  endtask

  task automatic step(string tag, logic av, int as, int aw, logic vr, int vs);
    @(negedge clk);
    acc_vld = av; acc_set = SW'(as); acc_way = WW'(aw);
    vic_req = vr; vic_set = SW'(vs);
    #2;
    if (vr) chk(tag, pick(mflags[vic_set], mlfsr[WW-1:0]));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: clear flags, victim equals start point
    for (int s = 0; s < 4; s++) begin
      step("R1", 0, 0, 0, 1, s);
      chk("R1_start", mlfsr[WW-1:0]);
    end
    // R2/R5: fill set 3 ways 0..2, victim must be way 3
    step("R2", 1, 3, 0, 0, 0);
    step("R2", 1, 3, 1, 0, 0);
    step("R2", 1, 3, 2, 0, 0);
    for (int i = 0; i < 4; i++) begin
      step("R5", 0, 0, 0, 1, 3);
      chk("R5_only_way3", WW'(3));
    end
    // R3: completing set 3 leaves only way 3 set
    step("R3", 1, 3, 3, 0, 0);
    for (int i = 0; i < 6; i++) begin
      step("R3", 0, 0, 0, 1, 3);
      n_cmp++;
      if (vic_way == WW'(3)) begin
        n_bad++;
        $display("FAIL R3: vic_way=%0d expected not 3", vic_way);
      end
    end
    // R7: same-set collision uses pre-update flags
    step("R7", 1, 7, 0, 0, 0);
    step("R7", 1, 7, 1, 0, 0);
    step("R7", 1, 7, 2, 0, 0);
    step("R7", 1, 7, 3, 1, 7);
    chk("R7_pre", WW'(3));
    // R8: hammer set 9, set 10 untouched
    for (int i = 0; i < 8; i++) step("R8", 1, 9, i % 3, 0, 0);
    for (int i = 0; i < 4; i++) begin
      step("R8", 0, 0, 0, 1, 10);
      chk("R8_isolated", mlfsr[WW-1:0]);
    end
    // R4/R5/R6/R9: random traffic
    for (int i = 0; i < 4000; i++)
      step("R4_R5_R6_R9", 1'($urandom), int'($urandom % SETS), int'($urandom % WAYS),
           1'($urandom), int'($urandom % SETS));
    // R1: reset mid-run clears all sets
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; acc_vld = 1'b0;
    for (int s = 0; s < SETS; s++) begin
      step("R1", 0, 0, 0, 1, s);
      chk("R1_after", mlfsr[WW-1:0]);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule